// File: doc/BRIEF.md
# PLL Frequency Lock Monitor

This block watches a clock-generator PLL from the digital side. It takes the divided reference clock and the divided VCO feedback clock, synchronizes both into the system clock domain and counts their rising edges there. A measurement window is a fixed number of reference edges, so a window lasts longer as the reference slows. Each window produces a count of feedback edges. The block compares that count with a programmed expected count, which makes it a frequency comparison and not a phase comparison.

The block checks the count error against two tolerance bands. The wide band selects whether the loop filter runs in acquisition mode (large corrections) or tracking mode (small corrections). The narrow band decides whether the VCO clock is lock-qualified, and therefore safe to use as the base clock.

In automatic mode the block sets both indications itself. In manual mode software selects the filter mode directly, and the lock flag is held low. A change of the lock state can latch an interrupt flag, which software clears by writing a one to it.

Top module: `pll_lock_monitor`

## Requirements
- R1: After reset, acq_o, lock_o and irq_o are 0. The control register reads 1, with automatic mode on and the other control bits off. The tolerance register reads 16'h0208 (acquisition tolerance 8, lock tolerance 2). The expected-count register reads EXP_RST.
- R2: A window ends on every WIN_LEN-th rising edge of the reference clock. The window's count is the number of feedback rising edges seen since the previous window end. The window duration, and so the expected count, scales with the reference period.
- R3: In automatic mode, acq_o is 1 if the most recent window's absolute count error was at most the acquisition tolerance, and 0 otherwise. In automatic mode acq_o changes only at window ends.
- R4: In automatic mode, lock_o rises only after two consecutive windows whose error is at most the lock tolerance. lock_o falls after a single window whose error exceeds the lock tolerance.
- R5: With automatic mode off, acq_o follows the software mode bit, and lock_o is 0 regardless of the feedback frequency.
- R6: Any change of lock_o sets the interrupt flag (irq_o, status bit 2) only while the interrupt enable bit is 1. With the enable at 0, a lock change leaves the flag at 0.
- R7: Writing a 1 to bit 0 at address 3 clears the interrupt flag. A new lock change in the same cycle wins over the clear.
- R8: The register map is as follows. Address 0 is control: bit 0 selects automatic mode, bit 1 is the software mode bit (1 = tracking), bit 2 is the interrupt enable. Address 1 is the expected count. Address 2 holds the tolerances, with acquisition in [7:0] and lock in [15:8]. Address 3 reads status: bit 0 acq, bit 1 lock, bit 2 interrupt flag. Written values read back on rdata through the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_div_i | input | 1 | Divided reference clock, asynchronous |
| fb_div_i | input | 1 | Divided VCO feedback clock, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for writes and reads |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for addr |
| acq_o | output | 1 | Filter mode: 0 acquisition, 1 tracking |
| lock_o | output | 1 | Lock-qualified flag |
| irq_o | output | 1 | Latched lock-change interrupt flag |

## Verification
The hardest point to reach from the ports is the two-window qualification of lock. The bench cannot see window boundaries, and the window in which the feedback frequency changes holds a mix of the old and new rates. The stimulus moves the feedback period from far out of band to exactly in band. It then waits for the rising edge of acq_o, which can only come at a window end. At that edge lock_o must still be 0, and it must be 1 two windows later. Retuning by period steps of a few nanoseconds places the error between the two bands, or outside both of them, or inside both.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int WIN_LEN      = 256,
  parameter int DW           = 16,
  parameter int EXP_RST      = 1024,
  parameter int ACQ_TOL_RST  = 8,
  parameter int LOCK_TOL_RST = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_div_i,
  input  logic          fb_div_i,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          acq_o,
  output logic          lock_o,
  output logic          irq_o
);
  localparam int WW = $clog2(WIN_LEN);
  localparam int TW = DW / 2;

  logic [2:0]    ref_s, fb_s;
  logic [WW-1:0] win_cnt;
  logic [DW-1:0] fb_cnt, exp_q;
  logic [TW-1:0] acq_tol, lock_tol;
  logic          auto_q, sw_trk, irq_en;
  logic          trk_q, lock_q, pend_q, lock_prev, flag_q;

  wire ref_rise = ref_s[1] & ~ref_s[2];
  wire fb_rise  = fb_s[1] & ~fb_s[2];
  wire win_done = ref_rise && (win_cnt == WW'(WIN_LEN - 1));
  wire [DW-1:0] meas = fb_cnt + DW'(fb_rise);
  wire [DW-1:0] err  = (meas >= exp_q) ? meas - exp_q : exp_q - meas;
  wire in_acq  = err <= DW'(acq_tol);
  wire in_lock = err <= DW'(lock_tol);
  wire w_ctrl  = wr_en && addr == 2'd0;
  wire clr     = wr_en && addr == 2'd3 && wdata[0];
  wire chg     = lock_q ^ lock_prev;

  assign acq_o  = auto_q ? trk_q : sw_trk;
  assign lock_o = lock_q;
  assign irq_o  = flag_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_s <= '0;
      fb_s  <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_div_i};
      fb_s  <= {fb_s[1:0], fb_div_i};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_cnt <= '0;
      fb_cnt  <= '0;
    end else begin
      if (win_done)      win_cnt <= '0;
      else if (ref_rise) win_cnt <= win_cnt + 1'b1;
      if (win_done)      fb_cnt <= '0;
      else if (fb_rise)  fb_cnt <= fb_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      auto_q   <= 1'b1;
      sw_trk   <= 1'b0;
      irq_en   <= 1'b0;
      exp_q    <= DW'(EXP_RST);
      acq_tol  <= TW'(ACQ_TOL_RST);
      lock_tol <= TW'(LOCK_TOL_RST);
    end else if (wr_en) begin
      case (addr)
        2'd0: {irq_en, sw_trk, auto_q} <= wdata[2:0];
        2'd1: exp_q <= wdata;
        2'd2: {lock_tol, acq_tol} <= wdata[2*TW-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trk_q  <= 1'b0;
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (!auto_q || (w_ctrl && !wdata[0])) begin
      lock_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (win_done) begin
      trk_q  <= in_acq;
      pend_q <= in_lock;
      lock_q <= in_lock && pend_q;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_prev <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      lock_prev <= lock_q;
      flag_q    <= (flag_q && !clr) || (chg && irq_en);
    end

  always_comb
    case (addr)
      2'd0:    rdata = {{(DW-3){1'b0}}, irq_en, sw_trk, auto_q};
      2'd1:    rdata = exp_q;
      2'd2:    rdata = {{(DW-2*TW){1'b0}}, lock_tol, acq_tol};
      default: rdata = {{(DW-3){1'b0}}, flag_q, lock_q, acq_o};
    endcase
endmodule

// File: rtl/pll_lock_monitor_chk.sv
module pll_lock_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_q,
  input logic irq_en,
  input logic win_done,
  input logic pend_q,
  input logic acq_o,
  input logic lock_o,
  input logic irq_o
);
  assert_lock_two_windows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(win_done) && $past(pend_q));

  assert_manual_no_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_q |=> !lock_o);

  assert_acq_at_window_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_q && $past(auto_q) && !$stable(acq_o)) |-> $past(win_done));

  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_en));
endmodule

bind pll_lock_monitor pll_lock_monitor_chk chk_i (
  .clk(clk), .rst_n(rst_n), .auto_q(auto_q), .irq_en(irq_en),
  .win_done(win_done), .pend_q(pend_q), .acq_o(acq_o),
  .lock_o(lock_o), .irq_o(irq_o)
);

// File: tb/pll_lock_monitor_tb_top.sv
`timescale 1ns/1ps
module pll_lock_monitor_tb_top;
  localparam real CLK_PERIOD = 10.0;
  localparam int  WIN = 32;
  localparam int  DW  = 16;

  logic clk = 0, rst_n = 0, ref_clk = 0, fb_clk = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [DW-1:0] wdata = 0, rdata;
  logic acq_o, lock_o, irq_o;
  real ref_half = 80.0, fb_half = 18.0;
  real win_ns;
  int total = 0, bad = 0;

  pll_lock_monitor #(.WIN_LEN(WIN), .DW(DW), .EXP_RST(128)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_div_i(ref_clk), .fb_div_i(fb_clk),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .acq_o(acq_o), .lock_o(lock_o), .irq_o(irq_o));

  always #(CLK_PERIOD/2) clk = ~clk;
  initial forever #(ref_half) ref_clk = ~ref_clk;
  initial forever #(fb_half) fb_clk = ~fb_clk;

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_win(real n);
    win_ns = 2.0 * ref_half * WIN;
    #(win_ns * n);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    @(negedge clk);
    chk("R1 acq", acq_o, 0); chk("R1 lock", lock_o, 0); chk("R1 irq", irq_o, 0);
    rd(0, d); chk("R1 ctrl", d, 16'h0001);
    rd(1, d); chk("R1 exp", d, 16'd128);
    rd(2, d); chk("R1 tol", d, 16'h0208);
  endtask

  task automatic t_lock_seq;
    fb_half = 18.0; wait_win(3.0);
    chk("R3 far acq", acq_o, 0); chk("R4 far lock", lock_o, 0);
    fb_half = 20.0;
    @(posedge acq_o); #2;
    chk("R4 one window not enough", lock_o, 0);
    wait_win(2.3);
    chk("R4 locked", lock_o, 1); chk("R3 tracking", acq_o, 1);
    chk("R6 no irq while disabled", irq_o, 0);
  endtask

  task automatic t_drift_irq;
    logic [DW-1:0] d;
    wr(0, 16'h0005);
    fb_half = 19.0; wait_win(2.5);
    chk("R4 unlock", lock_o, 0); chk("R3 inside wide band", acq_o, 1);
    chk("R6 irq set", irq_o, 1);
    rd(3, d); chk("R8 status", d, 16'h0005);
    wr(3, 16'h0001); @(negedge clk);
    chk("R7 w1c", irq_o, 0);
    fb_half = 18.0; wait_win(2.5);
    chk("R3 outside wide band", acq_o, 0);
    chk("R7 stays clear without lock change", irq_o, 0);
  endtask

  task automatic t_manual;
    wr(0, 16'h0002); fb_half = 20.0; wait_win(3.5);
    chk("R5 acq follows sw", acq_o, 1); chk("R5 lock forced off", lock_o, 0);
    wr(0, 16'h0000); @(negedge clk);
    chk("R5 acq sw off", acq_o, 0);
  endtask

  task automatic t_tol;
    logic [DW-1:0] d;
    wr(0, 16'h0001); fb_half = 18.0;
    wr(2, 16'h0210); rd(2, d); chk("R8 tol readback", d, 16'h0210);
    wait_win(3.0);
    chk("R3 wide tol acq", acq_o, 1); chk("R4 wide tol no lock", lock_o, 0);
    wr(1, 16'd142); rd(1, d); chk("R8 exp readback", d, 16'd142);
    wait_win(3.5);
    chk("R4 lock at new expected", lock_o, 1);
  endtask

  task automatic t_ref_scale;
    wr(2, 16'h0208); wr(1, 16'd128);
    ref_half = 160.0; fb_half = 20.0; wait_win(3.5);
    chk("R2 slow ref doubles count", lock_o, 0);
    wr(1, 16'd256); wait_win(3.5);
    chk("R2 lock at doubled count", lock_o, 1);
  endtask

  initial begin
    #(CLK_PERIOD*3.3) rst_n = 1;
    t_reset; t_lock_seq; t_drift_irq; t_manual; t_tol; t_ref_scale;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*190000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule